// File: doc/BRIEF.md
# Crystal-Referenced Speed Discriminator

This block judges the rotational speed of a motor from its tachometer pulse train. It uses a fast crystal clock as the reference. A prescaler divides that clock into reference ticks. A period counter counts the ticks between rising edges of the tachometer signal. The result is compared with a fixed nominal count. At the defaults the nominal count is 512 ticks of a divide-by-16 prescaler, so the target tachometer frequency is the crystal frequency over 8192.

The tachometer periods are taken in pairs. The first period of a pair is measured, and the outputs are refreshed at the edge that closes it. The second period only restarts the counter, so one new result appears for every two tachometer cycles. The result has three parts:

- a single-bit request that is high to speed up and low to slow down;
- a deviation magnitude that a following duty-cycle stage scales its correction by;
- an active-low lock flag that is low while the measured count is within a tolerance of nominal (±32 counts, or ±6.25%, at the defaults).

A stalled motor makes the counter saturate. That forces a maximally slow, unlocked result without waiting for another tachometer edge.

Top module: `fg_speed_discrim`

## Requirements
- R1: With rising tachometer edges T crystal clocks apart, the measured count is floor((T-1)/PRESCALE), limited to 2^CNT_W-1. The tick phase restarts at every edge.
- R2: The outputs change only at every second rising edge, or on saturation. At the other edges the outputs keep their previous values.
- R3: `accel` is 1 when the measured count exceeds NOMINAL (motor slow), and 0 otherwise.
- R4: `lock_n` is 0 exactly when |count − NOMINAL| ≤ LOCK_TOL, and 1 otherwise.
- R5: `dev_mag` equals |count − NOMINAL| when outside the lock window, and 0 when inside it.
- R6: If no edge arrives before the counter reaches 2^CNT_W−1, the outputs are forced on the next clock to `accel`=1, `lock_n`=1 and `dev_mag`=2^CNT_W−1−NOMINAL. The pairing also restarts, so the next edge opens a fresh measurement.
- R7: During and after reset, `accel`=0, `dev_mag`=0 and `lock_n`=1.
- R8: When an edge falls on the same cycle as a prescaler tick, the edge wins. That tick is not counted, and the counter restarts at 0.
- R9: After reset, the first edge only opens a measurement. `lock_n` stays 1 until the second edge delivers a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fg_in | input | 1 | Tachometer pulse, asynchronous to clk; two-flop synchronized inside |
| accel | output | 1 | 1 = speed up, 0 = slow down |
| dev_mag | output | CNT_W | Deviation magnitude in ticks, 0 inside the lock window |
| lock_n | output | 1 | 0 while speed is within the lock window |

## Verification
A tachometer edge and a prescaler tick can land in the same crystal cycle. The edge must then restart the counter and drop the tick. The bench provokes this by spacing edges at an exact multiple of the prescale ratio. It expects one count fewer than the spacing one clock longer gives. Saturation and an edge can also meet. That case is judged by letting the tachometer stop until the counter saturates. The bench then confirms both the forced slow result and a clean relock on the next pulse train.

// File: rtl/fg_speed_discrim.sv
module fg_speed_discrim #(
  parameter int PRESCALE = 16,
  parameter int NOMINAL  = 512,
  parameter int LOCK_TOL = 32,
  parameter int CNT_W    = $clog2(2 * NOMINAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fg_in,
  output logic             accel,
  output logic [CNT_W-1:0] dev_mag,
  output logic             lock_n
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] NOM_C    = CNT_W'(NOMINAL);
  localparam logic [CNT_W-1:0] TOL_C    = CNT_W'(LOCK_TOL);

  logic [2:0]       fg_sh;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic             phase;

  wire              fg_rise = fg_sh[1] & ~fg_sh[2];
  wire              slow    = cnt > NOM_C;
  wire [CNT_W-1:0]  mag     = slow ? cnt - NOM_C : NOM_C - cnt;
  wire              in_win  = mag <= TOL_C;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg_sh   <= '0;
      pre     <= '0;
      cnt     <= '0;
      phase   <= 1'b0;
      accel   <= 1'b0;
      dev_mag <= '0;
      lock_n  <= 1'b1;
    end else begin
      fg_sh <= {fg_sh[1:0], fg_in};
      if (fg_rise) begin
        pre   <= '0;
        cnt   <= '0;
        phase <= ~phase;
        if (phase) begin
          accel   <= slow;
          lock_n  <= ~in_win;
          dev_mag <= in_win ? '0 : mag;
        end
      end else if (cnt == CNT_MAX) begin
        phase   <= 1'b0;
        accel   <= 1'b1;
        lock_n  <= 1'b1;
        dev_mag <= CNT_MAX - NOM_C;
      end else begin
        pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
        if (pre == PRE_LAST) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module fg_speed_discrim_chk #(
  parameter int CNT_W    = 10,
  parameter int NOMINAL  = 512,
  parameter int LOCK_TOL = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accel,
  input logic [CNT_W-1:0] dev_mag,
  input logic             lock_n,
  input logic             rise,
  input logic             phase,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rise && phase) && !(cnt == CNT_MAX && !rise)) |=> $stable({accel, dev_mag, lock_n}));

  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_n |-> (dev_mag == '0 || dev_mag > CNT_W'(LOCK_TOL)));

  p_zero_in_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |-> dev_mag == '0);

  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !rise) |=> cnt == CNT_MAX || rise);

  p_stall_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !rise) |=> (accel && lock_n && !phase));

  p_edge_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> cnt == '0);

  p_slow_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && phase && cnt > CNT_W'(NOMINAL + LOCK_TOL)) |=> (accel && lock_n));
endmodule

bind fg_speed_discrim fg_speed_discrim_chk #(
  .CNT_W(CNT_W), .NOMINAL(NOMINAL), .LOCK_TOL(LOCK_TOL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .accel(accel), .dev_mag(dev_mag),
  .lock_n(lock_n), .rise(fg_rise), .phase(phase), .cnt(cnt)
);

// File: tb/fg_speed_discrim_bench.sv
module fg_speed_discrim_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P     = 4;
  localparam int NOM   = 32;
  localparam int TOL   = 2;
  localparam int CW    = $clog2(2 * NOM);
  localparam int MAXC  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fg_in = 1'b0;
  logic accel, lock_n;
  logic [CW-1:0] dev_mag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fg_speed_discrim #(.PRESCALE(P), .NOMINAL(NOM), .LOCK_TOL(TOL)) u_fg_speed_discrim (
    .clk(clk), .rst_n(rst_n), .fg_in(fg_in),
    .accel(accel), .dev_mag(dev_mag), .lock_n(lock_n));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic expect_count(input string tag, input int c);
    int mag;
    bit lk;
    mag = (c > NOM) ? c - NOM : NOM - c;
    lk  = (mag <= TOL);
    chk({tag, " R3 accel"}, accel, (c > NOM) ? 1 : 0);
    chk({tag, " R4 lock_n"}, lock_n, lk ? 0 : 1);
    chk({tag, " R5 dev_mag"}, dev_mag, lk ? 0 : mag);
  endtask

  task automatic pulse(input int t);
    fg_in = 1'b1;
    repeat (2) @(negedge clk);
    fg_in = 1'b0;
    repeat (t - 2) @(negedge clk);
  endtask

  task automatic train(input int t);
    for (int i = 0; i < 5; i++) pulse(t);
  endtask

  function automatic int cnt_of(input int t);
    int c;
    c = (t - 1) / P;
    return (c > MAXC) ? MAXC : c;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    chk("R7 accel in reset", accel, 0);
    chk("R7 lock_n in reset", lock_n, 1);
    chk("R7 dev_mag in reset", dev_mag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    pulse(NOM * P + 1);
    chk("R9 lock_n after first edge", lock_n, 1);
    chk("R9 dev_mag after first edge", dev_mag, 0);
    pulse(NOM * P + 1);
    expect_count("R9 R1 first result", NOM);
    pulse(50 * P + 1);
    expect_count("R2 hold at unpaired edge", NOM);
    pulse(50 * P + 1);
    expect_count("R2 R1 next paired result", 50);

    for (int m = 20; m <= 62; m++) begin
      train(m * P + 1);
      expect_count("R1 sweep", cnt_of(m * P + 1));
    end

    for (int m = 30; m <= 36; m++) begin
      train(m * P);
      expect_count("R8 edge on tick", m - 1);
    end

    fg_in = 1'b0;
    repeat ((MAXC + 2) * P + 10) @(negedge clk);
    chk("R6 stall accel", accel, 1);
    chk("R6 stall lock_n", lock_n, 1);
    chk("R6 stall dev_mag", dev_mag, MAXC - NOM);
    train(NOM * P + 1);
    expect_count("R6 relock after stall", NOM);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule